// File: doc/BRIEF.md
# CAN Base Frame Transmitter

This block sends one base-format CAN frame, a data frame or a remote request, onto a logical transmit line. Logic 0 on that line is dominant and logic 1 is recessive. The host presents an 11-bit identifier, a remote flag, a 4-bit length code and eight data bytes, then pulses `start`. A bit-timing unit outside the block supplies `bit_tick`, one pulse per bit time. The block moves one bit per tick.

The block compares every bit it sends with the sampled bus line `rx`. If it sends recessive in the identifier or remote field but reads dominant, another node has a higher-priority frame. The block then stops at once and reports the loss. The block adds the 15-bit CRC and inserts the stuff bits itself. It sends the acknowledge slot as recessive and flags an acknowledge error if no receiver pulls that slot dominant. It then sends seven end-of-frame bits and three intermission bits, and only after those is it ready for a new frame.

Top module: `can_tx_frame`

## Requirements
- R1: After reset `tx` is 1 and `busy`, `done`, `arb_lost` and `ack_err` are 0. While `busy` is low, `tx` stays 1.
- R2: A `start` sampled while `busy` is low has these effects:
  - the block latches `id`, `rtr`, `dlc` and `data`;
  - `busy` rises on the next clock, with `tx` still 1;
  - the dominant start bit appears on the clock after the next `bit_tick`.
  A `start` pulse or an input change while `busy` is high has no effect on the frame being sent.
- R3: Before stuffing, the frame is sent in this bit order:
  - one start bit 0;
  - `id`, most significant bit first;
  - the remote bit, 0 for a data frame (`rtr`=0) and 1 for a remote frame (`rtr`=1);
  - two reserved bits, both 0;
  - `dlc`, most significant bit first;
  - the data bytes in rising byte number k, where byte k is `data[8k+7:8k]`, each byte most significant bit first.
- R4: The number of data bytes sent is 0 for a remote frame. Otherwise it is the smaller of `dlc` and 8.
- R5: After the data, 15 CRC bits follow, most significant bit first. The CRC uses polynomial 0x4599 (x^15+x^14+x^10+x^8+x^7+x^4+x^3+1), starts from zero, and covers the unstuffed bits from the start bit through the last data bit.
- R6: From the start bit through the last CRC bit, a complementary stuff bit is inserted after any five equal consecutive bits on `tx`. Stuff bits count as part of the run. This applies after the last CRC bit as well.
- R7: After the CRC, the block sends 13 recessive bits with no stuffing, in this order: the CRC delimiter, the acknowledge slot, the acknowledge delimiter, seven end-of-frame bits and three intermission bits.
- R8: Suppose that in a non-stuff identifier or remote bit the block sends 1 and reads `rx`=0 at `bit_tick`. Then on the next clock `tx` returns to 1, `busy` falls, and `arb_lost` rises and stays high until the next accepted `start`. Equal bits do not end the frame.
- R9: If `rx` reads 1 at the tick that ends the acknowledge slot, `ack_err` is set and stays set until the next accepted `start`. A dominant acknowledge slot leaves `ack_err` at 0.
- R10: `done` is a one-clock pulse on the clock after the tick that ends the last end-of-frame bit. `busy` falls on the clock after the tick that ends the third intermission bit.
- R11: `tx` changes only on the clock after a `bit_tick`, so every bit lasts one full tick interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-clock pulse marking the end of each bit time |
| start | input | 1 | Request to send a frame; taken only while idle |
| id | input | 11 | Frame identifier; a lower value has higher priority |
| rtr | input | 1 | 1 requests a remote frame, 0 sends a data frame |
| dlc | input | 4 | Length code; values above 8 send 8 bytes |
| data | input | 64 | Payload; byte k is `data[8k+7:8k]` and byte 0 is sent first |
| rx | input | 1 | Sampled bus level (0 dominant) |
| tx | output | 1 | Transmit line (0 dominant, 1 recessive) |
| busy | output | 1 | High from an accepted start until the intermission ends or arbitration is lost |
| done | output | 1 | One-clock pulse when end-of-frame is complete |
| arb_lost | output | 1 | Arbitration was lost on the last attempt |
| ack_err | output | 1 | The acknowledge slot stayed recessive on the last frame |

## Verification
The bench builds the block with its default parameters: an 11-bit identifier, a 4-bit length, eight data bytes, a stuff run of five, seven end-of-frame bits and three intermission bits. It pulses `bit_tick` every fourth clock. These settings bring the following cases within reach:
- a full 64-bit data field;
- length codes above 8 being clamped;
- all-zero and all-one payloads that force a stuff bit at every possible run, including the run that closes the CRC.

A second modelled node shares the wired-AND bus. With it the bench can make the block lose arbitration on an identifier bit and on the remote bit, and can check that an identical identifier does not end the frame.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ARM, PH_BODY, PH_TAIL} phase_t;
  localparam int CRC_W = 15;
  localparam logic [CRC_W-1:0] CRC_POLY = 15'h4599;
endpackage

// File: rtl/can_tx_crc.sv
module can_tx_crc #(
  parameter int W = can_tx_pkg::CRC_W,
  parameter logic [W-1:0] POLY = can_tx_pkg::CRC_POLY
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         en,
  input  logic         bit_in,
  output logic [W-1:0] crc
);
  function automatic logic [W-1:0] crc_step(input logic [W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[W-1];
    return {c[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  endfunction

  // clear restarts the register from zero on the same edge as the first bit
  always_ff @(posedge clk) begin
    if (rst) crc <= '0;
    else if (en) crc <= crc_step(clear ? '0 : crc, bit_in);
  end
endmodule

// File: rtl/can_tx_stuff.sv
module can_tx_stuff #(
  parameter int RUN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic restart,
  input  logic bit_in,
  output logic need_stuff,
  output logic run_bit
);
  localparam int CNT_W = $clog2(RUN + 1);
  logic [CNT_W-1:0] cnt_q;

  // run length of the bits already placed on the line
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      run_bit <= 1'b1;
    end else if (en) begin
      run_bit <= bit_in;
      if (restart || bit_in != run_bit) cnt_q <= CNT_W'(1);
      else if (cnt_q != CNT_W'(RUN)) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign need_stuff = (cnt_q == CNT_W'(RUN));
endmodule

// File: rtl/can_tx_bitsel.sv
module can_tx_bitsel #(
  parameter int ID_W      = 11,
  parameter int LEN_W     = 4,
  parameter int MAX_BYTES = 8,
  parameter int CRC_W     = 15,
  parameter int POS_W     = 7
) (
  input  logic [POS_W-1:0]       pos,
  input  logic [POS_W-1:0]       dend,
  input  logic [ID_W-1:0]        id,
  input  logic                   rtr,
  input  logic [LEN_W-1:0]       dlc,
  input  logic [8*MAX_BYTES-1:0] data,
  input  logic [CRC_W-1:0]       crc,
  output logic                   bit_out
);
  localparam int HDR    = ID_W + 4 + LEN_W;
  localparam int DBITS  = 8 * MAX_BYTES;
  localparam int ID_IW  = (ID_W  > 1) ? $clog2(ID_W)  : 1;
  localparam int LEN_IW = (LEN_W > 1) ? $clog2(LEN_W) : 1;
  localparam int DAT_IW = (DBITS > 1) ? $clog2(DBITS) : 1;
  localparam int CRC_IW = $clog2(CRC_W);

  // unstuffed bit number -> line value
  always_comb begin
    int p, d, k;
    p = int'(pos);
    d = int'(dend);
    k = p - HDR;
    bit_out = 1'b1;
    if (p == 0)                 bit_out = 1'b0;
    else if (p <= ID_W)         bit_out = id[ID_IW'(ID_W - p)];
    else if (p == ID_W + 1)     bit_out = rtr;
    else if (p <= ID_W + 3)     bit_out = 1'b0;
    else if (p < HDR)           bit_out = dlc[LEN_IW'(HDR - 1 - p)];
    else if (p < d)             bit_out = data[DAT_IW'(8 * (k / 8) + 7 - (k % 8))];
    else if (p < d + CRC_W)     bit_out = crc[CRC_IW'(CRC_W - 1 - (p - d))];
  end
endmodule

// File: rtl/can_tx_frame.sv
module can_tx_frame #(
  parameter int ID_W      = 11,
  parameter int LEN_W     = 4,
  parameter int MAX_BYTES = 8,
  parameter int STUFF_RUN = 5,
  parameter int EOF_BITS  = 7,
  parameter int IFS_BITS  = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bit_tick,
  input  logic                   start,
  input  logic [ID_W-1:0]        id,
  input  logic                   rtr,
  input  logic [LEN_W-1:0]       dlc,
  input  logic [8*MAX_BYTES-1:0] data,
  input  logic                   rx,
  output logic                   tx,
  output logic                   busy,
  output logic                   done,
  output logic                   arb_lost,
  output logic                   ack_err
);
  import can_tx_pkg::*;

  localparam int HDR_BITS  = ID_W + 4 + LEN_W;
  localparam int DATA_BITS = 8 * MAX_BYTES;
  localparam int BODY_MAX  = HDR_BITS + DATA_BITS + CRC_W;
  localparam int TAIL_BITS = 3 + EOF_BITS + IFS_BITS;
  localparam int POS_MAX   = (BODY_MAX > TAIL_BITS) ? BODY_MAX : TAIL_BITS;
  localparam int POS_W     = $clog2(POS_MAX + 1);
  localparam int NB_W      = $clog2(MAX_BYTES + 1);
  localparam int ARB_LAST  = ID_W + 1;
  localparam int ACK_SLOT  = 1;
  localparam int EOF_LAST  = 2 + EOF_BITS;

  phase_t                 phase_q;
  logic [POS_W-1:0]       pos_q, pos_nxt, dend, body_last;
  logic [ID_W-1:0]        id_q;
  logic                   rtr_q;
  logic [LEN_W-1:0]       dlc_q;
  logic [DATA_BITS-1:0]   data_q;
  logic [NB_W-1:0]        nb_q, nb_in;
  logic                   tx_q, busy_q, done_q, arb_q, ack_q, stuff_q;
  logic [CRC_W-1:0]       crc;
  logic                   fbit, need_stuff, run_bit;
  logic                   arm_go, in_arb, lost, at_end;
  logic                   st_en, st_bit, crc_en, crc_bit;

  // byte count: none for a remote request, clamped at MAX_BYTES otherwise
  always_comb begin
    if (rtr)                        nb_in = '0;
    else if (int'(dlc) > MAX_BYTES) nb_in = NB_W'(MAX_BYTES);
    else                            nb_in = NB_W'(dlc);
  end

  assign dend      = POS_W'(HDR_BITS + 8 * int'(nb_q));
  assign body_last = dend + POS_W'(CRC_W - 1);
  assign pos_nxt   = pos_q + POS_W'(1);
  assign arm_go    = (phase_q == PH_ARM) && bit_tick;
  assign in_arb    = (phase_q == PH_BODY) && !stuff_q && (pos_q != '0) &&
                     (pos_q <= POS_W'(ARB_LAST));
  assign lost      = bit_tick && in_arb && tx_q && !rx;
  assign at_end    = (pos_q == body_last);

  assign st_en   = arm_go || (bit_tick && phase_q == PH_BODY && !lost && (need_stuff || !at_end));
  assign st_bit  = arm_go ? 1'b0 : (need_stuff ? ~run_bit : fbit);
  assign crc_en  = arm_go || (bit_tick && phase_q == PH_BODY && !lost && !need_stuff &&
                              !at_end && (pos_nxt < dend));
  assign crc_bit = arm_go ? 1'b0 : fbit;

  can_tx_bitsel #(
    .ID_W(ID_W), .LEN_W(LEN_W), .MAX_BYTES(MAX_BYTES), .CRC_W(CRC_W), .POS_W(POS_W)
  ) u_sel (
    .pos(pos_nxt), .dend(dend), .id(id_q), .rtr(rtr_q), .dlc(dlc_q),
    .data(data_q), .crc(crc), .bit_out(fbit)
  );

  can_tx_crc #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst(rst), .clear(arm_go), .en(crc_en), .bit_in(crc_bit), .crc(crc)
  );

  can_tx_stuff #(.RUN(STUFF_RUN)) u_stuff (
    .clk(clk), .rst(rst), .en(st_en), .restart(arm_go), .bit_in(st_bit),
    .need_stuff(need_stuff), .run_bit(run_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      pos_q   <= '0;
      id_q    <= '0;
      rtr_q   <= 1'b0;
      dlc_q   <= '0;
      data_q  <= '0;
      nb_q    <= '0;
      tx_q    <= 1'b1;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      arb_q   <= 1'b0;
      ack_q   <= 1'b0;
      stuff_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: if (start) begin
          id_q    <= id;
          rtr_q   <= rtr;
          dlc_q   <= dlc;
          data_q  <= data;
          nb_q    <= nb_in;
          busy_q  <= 1'b1;
          arb_q   <= 1'b0;
          ack_q   <= 1'b0;
          phase_q <= PH_ARM;
        end
        PH_ARM: if (bit_tick) begin
          phase_q <= PH_BODY;
          pos_q   <= '0;
          tx_q    <= 1'b0;
          stuff_q <= 1'b0;
        end
        PH_BODY: if (bit_tick) begin
          if (lost) begin
            phase_q <= PH_IDLE;
            tx_q    <= 1'b1;
            busy_q  <= 1'b0;
            arb_q   <= 1'b1;
          end else if (need_stuff) begin
            tx_q    <= ~run_bit;
            stuff_q <= 1'b1;
          end else if (at_end) begin
            phase_q <= PH_TAIL;
            pos_q   <= '0;
            tx_q    <= 1'b1;
            stuff_q <= 1'b0;
          end else begin
            pos_q   <= pos_nxt;
            tx_q    <= fbit;
            stuff_q <= 1'b0;
          end
        end
        PH_TAIL: if (bit_tick) begin
          if (pos_q == POS_W'(ACK_SLOT) && rx) ack_q <= 1'b1;
          if (pos_q == POS_W'(EOF_LAST)) done_q <= 1'b1;
          if (pos_q == POS_W'(TAIL_BITS - 1)) begin
            phase_q <= PH_IDLE;
            busy_q  <= 1'b0;
          end else begin
            pos_q <= pos_nxt;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign tx       = tx_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign arb_lost = arb_q;
  assign ack_err  = ack_q;
endmodule

// File: rtl/can_tx_chk.sv
module can_tx_chk (
  input logic clk,
  input logic rst,
  input logic bit_tick,
  input logic start,
  input logic rx,
  input logic tx,
  input logic busy,
  input logic done,
  input logic arb_lost,
  input logic ack_err
);
  // R11
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_tick) |-> $stable(tx));
  // R1
  idle_recessive_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R2
  arm_recessive_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> tx);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10
  done_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
  // R8
  lost_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_lost) |-> (!busy && tx));
  // R8
  lost_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_lost) |-> ($past(bit_tick) && !$past(rx)));
  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(arb_lost && ack_err));
endmodule

bind can_tx_frame can_tx_chk u_chk (
  .clk(clk), .rst(rst), .bit_tick(bit_tick), .start(start), .rx(rx), .tx(tx),
  .busy(busy), .done(done), .arb_lost(arb_lost), .ack_err(ack_err)
);

// File: tb/sim_can_tx_frame.sv
module sim_can_tx_frame;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, start, rtr, rx, tx, busy, done, arb_lost, ack_err;
  logic bit_tick = 1'b0;
  logic [10:0] id;
  logic [3:0]  dlc;
  logic [63:0] data;
  logic comp_drv = 1'b1, ack_drv = 1'b1;

  assign rx = tx & comp_drv & ack_drv;

  can_tx_frame u0 (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .start(start), .id(id), .rtr(rtr),
    .dlc(dlc), .data(data), .rx(rx), .tx(tx), .busy(busy), .done(done),
    .arb_lost(arb_lost), .ack_err(ack_err)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  string cur_tag = "R1";

  // bit tick every fourth clock
  int tdiv = 0;
  always @(negedge clk) begin
    if (tdiv == 3) begin tdiv <= 0; bit_tick <= 1'b1; end
    else begin tdiv <= tdiv + 1; bit_tick <= 1'b0; end
  end

  // ---- reference model ----
  bit b_bits[$], b_arb[$];
  int b_ack, b_eof;
  bit m_q[$], m_arbq[$], c_q[$];
  int m_st = 0, m_idx = 0, m_ack = 0, m_eof = 0;
  bit e_done = 0, e_arb = 0, e_ack = 0;
  bit comp_on = 0, ack_on = 1;
  logic [10:0] c_id;
  logic c_rtr;
  logic [3:0] c_dlc;
  logic [63:0] c_data;

  task automatic build(input logic [10:0] fid, input logic frtr, input logic [3:0] fdlc,
                       input logic [63:0] fdata);
    bit raw[$];
    int nb, run;
    logic [14:0] crc;
    bit fb, last;
    b_bits.delete(); b_arb.delete();
    raw.push_back(1'b0);
    for (int i = 10; i >= 0; i--) raw.push_back(fid[i]);
    raw.push_back(frtr); raw.push_back(1'b0); raw.push_back(1'b0);
    for (int i = 3; i >= 0; i--) raw.push_back(fdlc[i]);
    nb = frtr ? 0 : ((fdlc > 8) ? 8 : int'(fdlc));
    for (int k = 0; k < nb; k++)
      for (int b = 7; b >= 0; b--) raw.push_back(fdata[8*k+b]);
    crc = '0;
    foreach (raw[i]) begin
      fb = raw[i] ^ crc[14];
      crc = {crc[13:0], 1'b0};
      if (fb) crc = crc ^ 15'h4599;
    end
    for (int i = 14; i >= 0; i--) raw.push_back(crc[i]);
    run = 0; last = 1'b1;
    foreach (raw[i]) begin
      b_bits.push_back(raw[i]);
      b_arb.push_back(i >= 1 && i <= 12);
      if (i == 0 || raw[i] != last) run = 1; else run++;
      last = raw[i];
      if (run == 5) begin
        b_bits.push_back(~last); b_arb.push_back(1'b0);
        last = ~last; run = 1;
      end
    end
    b_ack = b_bits.size() + 1;
    b_eof = b_bits.size() + 9;
    for (int i = 0; i < 13; i++) begin b_bits.push_back(1'b1); b_arb.push_back(1'b0); end
  endtask

  always @(posedge clk) begin
    bit r;
    r = rx;
    e_done = 0;
    if (rst) begin
      m_st = 0; m_idx = 0; e_arb = 0; e_ack = 0;
    end else begin
      case (m_st)
        0: if (start) begin
          build(id, rtr, dlc, data);
          m_q = b_bits; m_arbq = b_arb; m_ack = b_ack; m_eof = b_eof;
          if (comp_on) begin build(c_id, c_rtr, c_dlc, c_data); c_q = b_bits; end
          e_arb = 0; e_ack = 0; m_st = 1;
        end
        1: if (bit_tick) begin m_st = 2; m_idx = 0; end
        default: if (bit_tick) begin
          if (m_arbq[m_idx] && m_q[m_idx] && !r) begin
            m_st = 0; e_arb = 1;
          end else begin
            if (m_idx == m_ack && r) e_ack = 1;
            if (m_idx == m_eof) e_done = 1;
            m_idx++;
            if (m_idx == m_q.size()) m_st = 0;
          end
        end
      endcase
    end
    comp_drv <= (comp_on && m_st == 2 && m_idx < c_q.size()) ? c_q[m_idx] : 1'b1;
    ack_drv  <= (ack_on && m_st == 2 && m_idx == m_ack) ? 1'b0 : 1'b1;
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk({cur_tag, " R11 tx"}, tx, (m_st == 2) ? m_q[m_idx] : 1'b1);
      chk("R2 R10 busy", busy, m_st != 0);
      chk("R10 done", done, e_done);
      chk("R8 arb_lost", arb_lost, e_arb);
      chk("R9 ack_err", ack_err, e_ack);
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic send(input string tag, input logic [10:0] fid, input logic frtr,
                      input logic [3:0] fdlc, input logic [63:0] fdata, input bit fack,
                      input bit fcomp, input logic [10:0] cid, input logic crtr,
                      input logic [63:0] cdata, input bit mid_start);
    @(negedge clk);
    cur_tag = tag;
    id = fid; rtr = frtr; dlc = fdlc; data = fdata;
    ack_on = fack; comp_on = fcomp;
    c_id = cid; c_rtr = crtr; c_dlc = fdlc; c_data = cdata;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (mid_start) begin
      repeat (150) @(negedge clk);
      id = ~fid; rtr = ~frtr; dlc = 4'd1; data = ~fdata;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (m_st != 0) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; rtr = 1'b0; id = '0; dlc = '0; data = '0;
    c_id = '0; c_rtr = 1'b0; c_dlc = '0; c_data = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tx", tx, 1'b1);
    chk("R1 busy", busy, 1'b0);
    chk("R1 done", done, 1'b0);
    chk("R1 arb_lost", arb_lost, 1'b0);
    chk("R1 ack_err", ack_err, 1'b0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    send("R3 R5 R6 R7 R10", 11'h123, 1'b0, 4'd2, 64'h0000_0000_0000_A55A, 1, 0, '0, 1'b0, '0, 0);
    send("R4 R6", 11'h000, 1'b0, 4'd8, 64'h0, 1, 0, '0, 1'b0, '0, 0);
    send("R4 R6", 11'h7FF, 1'b0, 4'd15, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, '0, 1'b0, '0, 0);
    send("R3 R4", 11'h2A5, 1'b1, 4'd4, 64'h1234_5678_9ABC_DEF0, 1, 0, '0, 1'b0, '0, 0);
    send("R9", 11'h155, 1'b0, 4'd1, 64'h0000_0000_0000_00C3, 0, 0, '0, 1'b0, '0, 0);
    send("R8", 11'h65A, 1'b0, 4'd3, 64'h0000_0000_0011_2233, 1, 1, 11'h64A, 1'b0, 64'h0, 0);
    send("R8", 11'h3C3, 1'b0, 4'd2, 64'h0000_0000_0000_F00F, 1, 1, 11'h3C3, 1'b0, 64'h0, 0);
    send("R8", 11'h0F0, 1'b1, 4'd2, 64'h0, 1, 1, 11'h0F0, 1'b0, 64'h0000_0000_0000_0101, 0);
    send("R2", 11'h4B1, 1'b0, 4'd5, 64'h0000_0099_8877_6655, 1, 0, '0, 1'b0, '0, 1);
    send("R2 R5", 11'h001, 1'b0, 4'd0, 64'h0, 1, 0, '0, 1'b0, '0, 0);
    repeat (10) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, got hang expected completion");
      finish_run();
    end
  end
endmodule